// File: doc/BRIEF.md
# Dual-Frequency Phase Engine for Direct Digital Synthesis

This block turns a master clock into a stream of sine amplitude samples. It holds two frequency tuning words and four phase offset words, which a parallel write port loads. On every rising clock edge a 32-bit phase accumulator adds whichever tuning word is currently selected. The output frequency is therefore the tuning word divided by 2^32, times the clock frequency. The top 12 accumulator bits, plus the selected phase offset, form an address into a quarter-wave sine table. The table result is expanded to a full period and presented as an 8-bit unsigned amplitude.

Switching between the two frequencies (frequency-shift keying) and between the four phase offsets (phase-shift keying) happens while the block runs. Each selection comes from one of two sources: external select pins, which are registered on the rising clock edge, or bits in a control register. A single source flag chooses between pins and bits for all three select lines. Writes to the tuning and offset registers never disturb the accumulator, so the generated phase stays continuous across a retune.

Top module: `dds_phase_core`

## Requirements
- R1: While `rst` is high at a rising edge, the following all clear: the accumulator, the two tuning words, the four offsets, the control register and the sampled pin selects. After that edge, `acc_out` reads 0 and `amp_out` reads 128 (mid-scale).
- R2: On each rising edge out of reset, `acc_out` becomes its previous value plus the selected tuning word, modulo 2^32.
- R3: A write with `wr_en` high stores `wr_data` at the rising edge, according to `wr_addr`. The address map is: 0 = tuning word 0 (all 32 bits), 1 = tuning word 1, 2..5 = phase offsets 0..3 (`wr_data[11:0]`), 6 = control (`wr_data[3:0]`). Address 7 changes nothing. A new tuning word is first used by the addition at the following edge, and no write alters the accumulator value.
- R4: Control bit 3 picks the select source: 0 = pins, 1 = control bits. With bit 3 at 1, control bit 0 is the frequency select and control bits 2:1 are the phase select.
- R5: With control bit 3 at 0, `fsel_pin` and `psel_pin` are registered at each rising edge. A change on a pin before edge k alters the accumulator step and the phase offset used at edge k+1, not at edge k.
- R6: With control bit 3 at 1, the select pins have no effect on `acc_out` or `amp_out`.
- R7: At each rising edge, the phase address is registered as `acc_out[31:20]` plus the selected 12-bit offset, modulo 4096. This happens one edge after the accumulator value it uses.
- R8: Let Q(i) = round(127·sin(π/2·(i+0.5)/1024)) for i = 0..1023. For a phase address with quadrant q = bits 11:10 and index j = bits 9:0, define i = j when q is even and i = 1023−j when q is odd. The amplitude is then 128+Q(i) for q = 0 or 1, and 127−Q(i) for q = 2 or 3. `amp_out` shows this amplitude two edges after the address is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; everything updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| fsel_pin | input | 1 | Frequency select pin |
| psel_pin | input | 2 | Phase offset select pins |
| acc_out | output | 32 | Phase accumulator value |
| amp_out | output | 8 | Unsigned sine amplitude |

## Verification
The table is swept end to end by a tuning word that advances the address by exactly one step per clock. The sweep runs once under each of four offsets, and each offset lands in a different quadrant. This separates errors in the mirroring, the sign inversion and the offset addition. Fixed accumulator values with chosen offsets hit the quadrant boundaries, where peak and trough values are known exactly. Deliberate pin and bit toggles, compared step by step, distinguish a one-cycle select latency from zero or two cycles. They also show that pins are ignored in bit mode and that an unused write address is inert. A large tuning word exposes wrap-around of the accumulator.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // Write-port register map (the encoding is visible at the port).
  typedef enum logic [2:0] {
    RA_FREQ0 = 3'd0,
    RA_FREQ1 = 3'd1,
    RA_PH0   = 3'd2,
    RA_PH1   = 3'd3,
    RA_PH2   = 3'd4,
    RA_PH3   = 3'd5,
    RA_CTRL  = 3'd6
  } reg_addr_e;

  // Bit positions inside the control word.
  localparam int CB_FSEL   = 0;
  localparam int CB_PSEL_L = 1;
  localparam int CB_SRC    = 3;
  localparam int CTRL_W    = 4;

endpackage

// File: rtl/dds_regfile.sv
module dds_regfile
  import dds_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12,
  parameter int NPH   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [2:0]                wr_addr,
  input  logic [ACC_W-1:0]          wr_data,
  output logic [ACC_W-1:0]          freq0_o,
  output logic [ACC_W-1:0]          freq1_o,
  output logic [NPH-1:0][PH_W-1:0]  phase_o,
  output logic [CTRL_W-1:0]         ctrl_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      freq0_o <= '0;
      freq1_o <= '0;
      ctrl_o  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'(RA_FREQ0): freq0_o <= wr_data;
        3'(RA_FREQ1): freq1_o <= wr_data;
        3'(RA_CTRL):  ctrl_o  <= wr_data[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NPH; g++) begin : g_phase
    always_ff @(posedge clk) begin
      if (rst)
        phase_o[g] <= '0;
      else if (wr_en && (int'(wr_addr) == int'(RA_PH0) + g))
        phase_o[g] <= wr_data[PH_W-1:0];
    end
  end

  // R3: without a write strobe the tuning words hold
  a_r3_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && !$past(rst)) |-> ($stable(freq0_o) && $stable(freq1_o)));

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] step_i,
  input  logic [PH_W-1:0]  offset_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [PH_W-1:0]  addr_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o  <= '0;
      addr_o <= '0;
    end else begin
      acc_o  <= acc_o + step_i;
      addr_o <= acc_o[ACC_W-1 -: PH_W] + offset_i;
    end
  end

endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut #(
  parameter int PH_W  = 12,
  parameter int AMP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PH_W-1:0]  addr_i,
  output logic [AMP_W-1:0] amp_o
);

  localparam int IDX_W = PH_W - 2;
  localparam int QN    = 1 << IDX_W;
  localparam int QW    = AMP_W - 1;
  localparam int PEAK  = (1 << QW) - 1;
  localparam logic [AMP_W-1:0] MID = AMP_W'(1 << QW);
  localparam real HALF_PI = 1.5707963267948966;

  logic [QW-1:0]    rom [QN];
  logic [QW-1:0]    rom_q;
  logic [1:0]       quad_q;
  logic [IDX_W-1:0] idx;

  initial begin
    for (int i = 0; i < QN; i++)
      rom[i] = QW'($rtoi(real'(PEAK) * $sin(HALF_PI * (real'(i) + 0.5) / real'(QN)) + 0.5));
  end

  // Odd quadrants read the quarter table backwards
  assign idx = addr_i[PH_W-2] ? ~addr_i[IDX_W-1:0] : addr_i[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_q  <= '0;
      quad_q <= '0;
    end else begin
      rom_q  <= rom[idx];
      quad_q <= addr_i[PH_W-1 -: 2];
    end
  end

  // Lower half-period is inverted about mid-scale
  always_ff @(posedge clk) begin
    if (rst)
      amp_o <= MID;
    else if (quad_q[1])
      amp_o <= (MID - AMP_W'(1)) - AMP_W'(rom_q);
    else
      amp_o <= MID + AMP_W'(rom_q);
  end

  // R8: first half-period of phase gives upper half of amplitude range
  a_r8_upper_half: assert property (@(posedge clk) disable iff (rst)
    (!$past(addr_i[PH_W-1], 2)) |-> (amp_o >= MID));

  // R8: second half-period gives lower half
  a_r8_lower_half: assert property (@(posedge clk) disable iff (rst)
    ($past(addr_i[PH_W-1], 2) && !$past(rst, 2)) |-> (amp_o < MID));

endmodule

// File: rtl/dds_phase_core.sv
module dds_phase_core
  import dds_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12,
  parameter int NPH   = 4,
  parameter int AMP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             fsel_pin,
  input  logic [1:0]       psel_pin,
  output logic [ACC_W-1:0] acc_out,
  output logic [AMP_W-1:0] amp_out
);

  localparam int PS_W = $clog2(NPH);
  localparam logic [AMP_W-1:0] MID = AMP_W'(1 << (AMP_W - 1));

  logic [ACC_W-1:0]         freq0, freq1, step;
  logic [NPH-1:0][PH_W-1:0] phase;
  logic [CTRL_W-1:0]        ctrl;
  logic                     fsel_q, fsel_eff;
  logic [PS_W-1:0]          psel_q, psel_eff;
  logic [PH_W-1:0]          ph_addr;

  dds_regfile #(.ACC_W(ACC_W), .PH_W(PH_W), .NPH(NPH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .freq0_o(freq0), .freq1_o(freq1), .phase_o(phase), .ctrl_o(ctrl)
  );

  // Pin selects registered on the rising edge
  always_ff @(posedge clk) begin
    if (rst) begin
      fsel_q <= 1'b0;
      psel_q <= '0;
    end else begin
      fsel_q <= fsel_pin;
      psel_q <= PS_W'(psel_pin);
    end
  end

  assign fsel_eff = ctrl[CB_SRC] ? ctrl[CB_FSEL] : fsel_q;
  assign psel_eff = ctrl[CB_SRC] ? ctrl[CB_PSEL_L +: PS_W] : psel_q;
  assign step     = fsel_eff ? freq1 : freq0;

  dds_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
    .clk(clk), .rst(rst), .step_i(step), .offset_i(phase[psel_eff]),
    .acc_o(acc_out), .addr_o(ph_addr)
  );

  dds_sine_lut #(.PH_W(PH_W), .AMP_W(AMP_W)) u_lut (
    .clk(clk), .rst(rst), .addr_i(ph_addr), .amp_o(amp_out)
  );

  // R1: reset leaves accumulator at zero and amplitude at mid-scale
  a_r1_reset_midscale: assert property (@(posedge clk)
    rst |=> (acc_out == '0 && amp_out == MID));

  // R5: in pin mode the frequency select follows the pin one edge later
  a_r5_pin_sampled: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[CB_SRC] && !$past(rst)) |-> (fsel_eff == $past(fsel_pin)));

  // R5: phase select likewise
  a_r5_psel_sampled: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[CB_SRC] && !$past(rst)) |-> (psel_eff == $past(PS_W'(psel_pin))));

endmodule

// File: tb/dds_phase_core_test.sv
module dds_phase_core_test;

  localparam int  CLK_PERIOD = 10;
  localparam real HALF_PI    = 1.5707963267948966;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        fsel_pin = 1'b0;
  logic [1:0]  psel_pin = '0;
  logic [31:0] acc_out;
  logic [7:0]  amp_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_phase_core uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fsel_pin(fsel_pin), .psel_pin(psel_pin), .acc_out(acc_out), .amp_out(amp_out)
  );

  // Expected amplitude for a 12-bit phase address (R8)
  function automatic logic [7:0] sine_exp(logic [11:0] a);
    int i, q;
    i = a[10] ? 1023 - int'(a[9:0]) : int'(a[9:0]);
    q = $rtoi(127.0 * $sin(HALF_PI * (real'(i) + 0.5) / 1024.0) + 0.5);
    return a[11] ? 8'(127 - q) : 8'(128 + q);
  endfunction

  // Reference model built from the requirements
  logic [31:0] m_acc, m_f0, m_f1;
  logic [11:0] m_ph [4];
  logic [3:0]  m_ctrl;
  logic        m_fs, fe;
  logic [1:0]  m_ps, pe;
  logic [11:0] m_addr, m_a2;
  logic [7:0]  m_amp;

  always @(posedge clk) begin
    if (rst) begin
      m_acc <= '0; m_f0 <= '0; m_f1 <= '0; m_ctrl <= '0;
      for (int k = 0; k < 4; k++) m_ph[k] <= '0;
      m_fs <= 1'b0; m_ps <= '0; m_addr <= '0; m_a2 <= '0; m_amp <= 8'd128;
    end else begin
      fe = m_ctrl[3] ? m_ctrl[0]   : m_fs;
      pe = m_ctrl[3] ? m_ctrl[2:1] : m_ps;
      m_acc  <= m_acc + (fe ? m_f1 : m_f0);
      m_addr <= m_acc[31:20] + m_ph[pe];
      m_a2   <= m_addr;
      m_amp  <= sine_exp(m_a2);
      m_fs   <= fsel_pin;
      m_ps   <= psel_pin;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_f0 <= wr_data;
          3'd1: m_f1 <= wr_data;
          3'd2, 3'd3, 3'd4, 3'd5: m_ph[wr_addr - 3'd2] <= wr_data[11:0];
          3'd6: m_ctrl <= wr_data[3:0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One clock; compare against the model at the falling edge
  task automatic cyc();
    @(negedge clk);
    check("R2 accumulator", acc_out, m_acc);
    check("R8 amplitude", 32'(amp_out), 32'(m_amp));
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(); cyc();
    check("R1 acc in reset", acc_out, 32'd0);
    check("R1 amp in reset", 32'(amp_out), 32'd128);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a0;
    do_reset();
    cyc();
    check("R1 acc stays zero with cleared words", acc_out, 32'd0);

    // R8 quadrant boundaries with a frozen accumulator (acc = 0)
    wr(3'd2, 32'd1024); repeat (4) cyc();
    check("R8 peak at quadrant 1 start", 32'(amp_out), 32'd255);
    wr(3'd2, 32'd3072); repeat (4) cyc();
    check("R8 trough at quadrant 3 start", 32'(amp_out), 32'd0);
    wr(3'd2, 32'd2048); repeat (4) cyc();
    check("R8 just below mid at half period", 32'(amp_out), 32'd127);
    wr(3'd2, 32'd0); repeat (4) cyc();
    check("R8 mid at zero phase", 32'(amp_out), 32'd128);

    // R2 wrap-around
    wr(3'd0, 32'hF000_0000);
    check("R3 write does not move acc", acc_out, 32'd0);
    cyc();
    check("R2 first step", acc_out, 32'hF000_0000);
    cyc();
    check("R2 wrap modulo 2^32", acc_out, 32'hE000_0000);

    // R5 frequency select timing
    do_reset();
    wr(3'd0, 32'd100); wr(3'd1, 32'd7);
    cyc();
    a0 = acc_out;
    fsel_pin = 1'b1;
    cyc();
    check("R5 step at sampling edge uses old word", acc_out, a0 + 32'd100);
    cyc();
    check("R5 step one edge later uses new word", acc_out, a0 + 32'd107);
    fsel_pin = 1'b0;

    // R3 unused address 7 is inert
    cyc();
    wr(3'd7, 32'hFFFF_FFFF);
    a0 = acc_out;
    cyc();
    check("R3 address 7 ignored", acc_out, a0 + 32'd100);

    // R6 / R4 bit source overrides pins
    wr(3'd6, 32'h8);
    a0 = acc_out;
    fsel_pin = 1'b1; psel_pin = 2'd3;
    cyc(); cyc();
    check("R6 pin ignored in bit mode", acc_out, a0 + 32'd200);
    wr(3'd6, 32'h9);
    a0 = acc_out;
    cyc();
    check("R4 control bit 0 picks word 1", acc_out, a0 + 32'd7);
    fsel_pin = 1'b0; psel_pin = 2'd0;

    // R7/R8/R9 sweep: one address step per clock under each offset
    do_reset();
    wr(3'd0, 32'h0010_0000);
    wr(3'd2, 32'd0); wr(3'd3, 32'd1031); wr(3'd4, 32'd2348); wr(3'd5, 32'd4095);
    for (int ps = 0; ps < 4; ps++) begin
      psel_pin = 2'(ps);
      for (int n = 0; n < 4096; n++) cyc();
    end

    // R4/R6 bit-selected offsets with toggling pins, R5 pin switching at speed
    wr(3'd1, 32'h0030_0005);
    wr(3'd6, 32'hD);
    for (int n = 0; n < 600; n++) begin
      fsel_pin = n[0]; psel_pin = n[2:1];
      cyc();
    end
    wr(3'd6, 32'h0);
    for (int n = 0; n < 600; n++) begin
      fsel_pin = n[1]; psel_pin = n[3:2];
      cyc();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule